// File: doc/BRIEF.md
# Start-Gated Strobe Decimator

This block counts occurrences of a short, repeating external strobe and produces one single-cycle completion pulse after a programmed number of them. It stays idle and ignores the strobe until a start command arms it. Once armed, it counts strobe occurrences. On the final occurrence it raises its done output for exactly one clock and disarms itself. A downstream state machine can use that pulse as its trigger.

The strobe does not share a clock with the block. Inside the block it passes through a two-flop synchronizer on the system clock. A rising-edge detector follows, so a strobe that stays high for several clocks is counted once. The strobe never clocks any register. The programmed count is 16 bits wide and is captured when start is accepted. A count of zero behaves like a count of one.

Top module: `strobe_decimator`

## Requirements
- R1: While `rst` (asynchronous, active high) is asserted, `done` is low. After reset the block is idle, so strobes that arrive before a start produce no pulse.
- R2: Strobe occurrences that arrive while the block is idle are not counted. After a later start, the number of strobes needed to reach the pulse is the full programmed count.
- R3: The latency is fixed. Let clock edge k be the first rising clock edge that samples `strobe_in` high. Then `done` goes high right after clock edge k+2, provided that strobe is the terminal occurrence.
- R4: `done` is high for exactly one clock per terminal occurrence. Afterwards the block is idle, and further strobes produce no pulse until the next start.
- R5: A strobe that stays high for many consecutive clocks counts as one occurrence.
- R6: A start that is asserted while counting is ignored. The occurrence count is not restarted.
- R7: When `count_val` is zero at the moment of arming, the pulse is produced on the first counted strobe, exactly as for a count of one.
- R8: `count_val` is captured when start is accepted in idle. Changing it during counting does not change the terminal occurrence.
- R9: If a start is accepted in idle in the same clock as a synchronized strobe edge, that edge is not counted. If a start arrives in the clock where the terminal edge is counted, the start is ignored and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Arms counting when sampled high in idle |
| strobe_in | input | 1 | Raw external strobe, asynchronous to `clk` |
| count_val | input | CNT_W (16) | Number of strobe occurrences per pulse; zero acts as one |
| done | output | 1 | Registered one-clock completion pulse |

## Verification
Two control functions can land on the same clock edge: accepting a start command and counting a synchronized strobe edge. The bench provokes this by raising the raw strobe and then raising start exactly two clocks later. That places start on the edge where the synchronized rising edge is seen. This is done once from idle, where the strobe must go uncounted and the pulse must come one strobe later than usual. It is done once on the terminal occurrence, where the pulse must appear and a follow-up strobe must produce nothing.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;

    // Control states of the decimator
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } ctrl_state_e;

    // Synchronized view of the external strobe
    typedef struct packed {
        logic level;   // synchronized strobe level
        logic rise;    // single-clock rising-edge indication
    } strobe_evt_t;

    localparam int DEF_CNT_W       = 16;
    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dec_strobe_sync.sv
module dec_strobe_sync
    import strobe_dec_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_raw,
    output strobe_evt_t evt
);

    localparam int LAST = STAGES - 1;

    logic chain [STAGES];
    logic prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= strobe_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    always_comb begin
        evt.level = chain[LAST];
        evt.rise  = chain[LAST] & ~prev_q;
    end

endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
    import strobe_dec_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rise,
    input  logic [CNT_W-1:0] count_val,
    output logic             done,
    output ctrl_state_e      state,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] target
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ctrl_state_e      state_q, state_d;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic [CNT_W-1:0] tgt_q, tgt_d;
    logic             done_q, done_d;
    logic             last_hit;

    // Terminal occurrence: count so far equals target minus one
    assign last_hit = (occ_q == (tgt_q - ONE));

    always_comb begin
        state_d = state_q;
        occ_d   = occ_q;
        tgt_d   = tgt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                occ_d = '0;
                if (start) begin
                    state_d = ST_COUNT;
                    tgt_d   = (count_val == '0) ? ONE : count_val;
                end
            end
            ST_COUNT: begin
                if (rise) begin
                    if (last_hit) begin
                        done_d  = 1'b1;
                        occ_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        occ_d = occ_q + ONE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            occ_q   <= '0;
            tgt_q   <= ONE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            tgt_q   <= tgt_d;
            done_q  <= done_d;
        end
    end

    assign done   = done_q;
    assign state  = state_q;
    assign occ    = occ_q;
    assign target = tgt_q;

endmodule

// File: rtl/strobe_decimator.sv
module strobe_decimator
    import strobe_dec_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             strobe_in,
    input  logic [CNT_W-1:0] count_val,
    output logic             done
);

    strobe_evt_t      strobe_evt;
    ctrl_state_e      ctrl_state;
    logic [CNT_W-1:0] occ_cnt;
    logic [CNT_W-1:0] target_cnt;

    dec_strobe_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk        (clk),
        .rst        (rst),
        .strobe_raw (strobe_in),
        .evt        (strobe_evt)
    );

    dec_ctrl #(
        .CNT_W(CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rise      (strobe_evt.rise),
        .count_val (count_val),
        .done      (done),
        .state     (ctrl_state),
        .occ       (occ_cnt),
        .target    (target_cnt)
    );

endmodule

// File: rtl/strobe_decimator_chk.sv
module strobe_decimator_chk
    import strobe_dec_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic             rise,
    input ctrl_state_e      state,
    input logic [CNT_W-1:0] occ,
    input logic [CNT_W-1:0] target
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R4

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state) == ST_COUNT && $past(rise)));  // R3

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE && !done));  // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (occ == '0));  // R2

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |=> $stable(target));  // R8

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |-> (occ < target));  // R7

endmodule

bind strobe_decimator strobe_decimator_chk #(.CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .rise   (strobe_evt.rise),
    .state  (ctrl_state),
    .occ    (occ_cnt),
    .target (target_cnt)
);

// File: tb/strobe_decimator_tb.sv
`timescale 1ns/1ps
module strobe_decimator_tb_top;

    localparam int CNT_W = 16;

    typedef struct packed {
        logic [15:0] cnt;
        logic [7:0]  nstb;
        logic [7:0]  hi;
        logic [7:0]  exp_idx;
        logic [7:0]  exp_np;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd3, 8'd5, 8'd2, 8'd3, 8'd1},   // R3 basic
        '{16'd1, 8'd3, 8'd4, 8'd1, 8'd1},   // R4 one-shot then idle
        '{16'd0, 8'd2, 8'd3, 8'd1, 8'd1},   // R7 zero acts as one
        '{16'd5, 8'd7, 8'd9, 8'd5, 8'd1},   // R5 long strobes
        '{16'd2, 8'd2, 8'd1, 8'd2, 8'd1},   // R3 short strobes
        '{16'd4, 8'd3, 8'd2, 8'd0, 8'd0}    // R3 terminal not reached
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             strobe_in = 1'b0;
    logic [CNT_W-1:0] count_val = '0;
    logic             done;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int last_idx = 0;
    int strobe_idx = 0;
    int width_errs = 0;
    logic prev_done = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strobe_decimator #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .strobe_in (strobe_in),
        .count_val (count_val),
        .done      (done)
    );

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && done) begin
            pulses   = pulses + 1;
            last_idx = strobe_idx;
            if (prev_done) width_errs = width_errs + 1;
        end
        prev_done = done;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; strobe_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        pulses = 0; last_idx = 0; strobe_idx = 0;
        @(negedge clk);
    endtask

    task automatic arm(input int cnt);
        count_val = CNT_W'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input int hi);
        strobe_idx++;
        strobe_in = 1'b1;
        repeat (hi) @(negedge clk);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        send(3); send(3);
        chk("R1 no pulse after reset without start", pulses, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            arm(int'(VECS[v].cnt));
            for (int s = 0; s < int'(VECS[v].nstb); s++) send(int'(VECS[v].hi));
            chk($sformatf("R3 vec%0d pulse count", v), pulses, int'(VECS[v].exp_np));
            chk($sformatf("R4 vec%0d pulse strobe index", v), last_idx, int'(VECS[v].exp_idx));
        end

        // R2: idle strobes ignored
        do_reset();
        count_val = 16'd2;
        send(2); send(2); send(2);
        arm(2);
        send(2);
        chk("R2 no pulse after first armed strobe", pulses, 0);
        send(2);
        chk("R2 pulse on second armed strobe", pulses, 1);

        // R3 latency and R4 width
        do_reset();
        arm(1);
        strobe_idx++;
        strobe_in = 1'b1;
        @(negedge clk); chk("R3 latency edge k", int'(done), 0);
        @(negedge clk); chk("R3 latency edge k+1", int'(done), 0);
        @(negedge clk); chk("R3 latency edge k+2", int'(done), 1);
        @(negedge clk); chk("R4 pulse width", int'(done), 0);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);

        // R6: start while counting ignored
        do_reset();
        arm(3);
        send(2);
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
        send(2);
        send(2);
        chk("R6 pulse count", pulses, 1);
        chk("R6 pulse at strobe 3", last_idx, 3);

        // R8: count captured at start
        do_reset();
        arm(2);
        count_val = 16'd5;
        send(2); send(2);
        chk("R8 pulse uses captured count", pulses, 1);
        chk("R8 pulse at strobe 2", last_idx, 2);

        // R9a: start coincides with strobe edge in idle
        do_reset();
        count_val = 16'd1;
        strobe_idx++;
        strobe_in = 1'b1;
        @(negedge clk); @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; strobe_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 coincident edge not counted", pulses, 0);
        send(2);
        chk("R9 pulse on next strobe", last_idx, 2);

        // R9b: start coincides with terminal edge
        do_reset();
        arm(1);
        strobe_idx++;
        strobe_in = 1'b1;
        @(negedge clk); @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; strobe_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 terminal pulse with start", pulses, 1);
        send(2);
        chk("R9 start at terminal ignored", pulses, 1);

        chk("R4 no double-wide pulse", width_errs, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule